// File: doc/BRIEF.md
# Asynchronous SRAM Chip-Select Controller

This block is a bus slave that maps one address region onto an external asynchronous static RAM. Software programs two 32-bit registers through a small single-word register port: a configuration word and a timing word. The configuration word holds the region's select field, the device data width, the memory type and an enable bit. The timing word holds cycle counts for the read strobe, the read turnaround, the write pulse, the write hold and the gap between writes. A 32-bit bus access that falls inside the enabled region becomes one or more device cycles. Accesses outside the region, or with an illegal width setting, get an error response.

A write always becomes a single device cycle that carries the low lanes of the bus data. A read always returns a full 32-bit word. For an 8-bit device the word is built from four device reads, and for a 16-bit device from two. Each device read lands in its own lane of the result, in ascending address order. The bus sees one acknowledge when the last device cycle has finished.

Control is one state machine with these states. `ST_IDLE` waits for a request. `ST_READ` holds the read strobe. `ST_TURN` releases the device bus after each read. `ST_WPULSE` holds the write strobe. `ST_WHOLD` keeps the data driven after the write strobe. `ST_WGAP` is the idle gap after a write. `ST_ACK` and `ST_ERR` each give a one-cycle response. The transitions are:
- idle to read, idle to write pulse, or idle to error, when a request is accepted;
- read to turnaround, when the read count expires;
- turnaround back to read while more sub-cycles remain, otherwise turnaround to ack;
- write pulse to hold, to gap or to ack, skipping any phase whose count is zero;
- hold to gap or to ack;
- gap to ack;
- ack and error back to idle.

Top module: `asram_cs_ctrl`

## Requirements
- R1: The configuration word (register offset 0x18) and the timing word (offset 0x1C) reset to zero and read back exactly the 32 bits last written, reserved bits included. Any other offset reads as zero.
- R2: An access hits the region only when the following all hold: bus address bits [28:21] equal configuration bits [23:16], configuration bit 0 is 1, and configuration bits [3:1] equal 2. A miss gets a one-cycle `bus_err` and starts no device cycle.
- R3: A hit while configuration bits [5:4] hold 3 gets a one-cycle `bus_err`. The width codes are 0 = 8-bit, 1 = 16-bit, 2 = 32-bit.
- R4: A write produces one device cycle. During it, `mem_we_n` is low for (timing bits [15:12]) + 1 cycles and `mem_drive` is high. The data is `bus_dat_w`, of which the device uses the low 8, 16 or 32 bits. The device address is the bus address bits [20:0] shifted right by 0, 1 or 2 for the 8-, 16- or 32-bit width.
- R5: A read produces 4, 2 or 1 device cycles for the 8-, 16- or 32-bit width. Sub-cycle k uses device address (bus address bits [20:2]) × count + k. In each sub-cycle `mem_oe_n` is low for (timing bits [7:0]) + 1 cycles, and the data is taken on the last of them.
- R6: After every read sub-cycle, `mem_oe_n` and `mem_cs_n` stay high for (timing bits [11:8]) + 1 cycles before the next sub-cycle or the acknowledge.
- R7: Read sub-cycle k places the device's low 8 bits at result bits [8k+7:8k] for the 8-bit width, and its low 16 bits at [16k+15:16k] for the 16-bit width. The upper bits that the device returns are ignored.
- R8: `bus_ack` is high for exactly one cycle, the cycle after the last device phase. `bus_ack` and `bus_err` are never high together.
- R9: After the write strobe rises, the data stays driven with `mem_cs_n` low for (timing bits [19:16]) cycles. The bus then idles for (timing bits [25:20]) cycles, and the acknowledge follows.
- R10: A write followed by a read of the same address returns the written data, whatever idle cycles are inserted before `bus_cyc` or `bus_stb` is raised.
- R11: A register write that lands in the same cycle as a request is accepted does not affect that request. The request is decoded against the configuration value held before the write.
- R12: `mem_we_n` and `mem_oe_n` are never low in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_en | input | 1 | Register port access strobe |
| reg_we | input | 1 | Register port write enable |
| reg_off | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, selected by `reg_off` |
| bus_cyc | input | 1 | Bus cycle in progress |
| bus_stb | input | 1 | Bus strobe; a request is `bus_cyc` and `bus_stb` both high |
| bus_we | input | 1 | Bus write (1) or read (0) |
| bus_adr | input | 32 | Bus byte address |
| bus_dat_w | input | 32 | Bus write data |
| bus_dat_r | output | 32 | Assembled read data, valid with `bus_ack` |
| bus_ack | output | 1 | One-cycle completion |
| bus_err | output | 1 | One-cycle error response |
| mem_adr | output | 21 | Device address |
| mem_dout | output | 32 | Data toward the device |
| mem_din | input | 32 | Data from the device |
| mem_drive | output | 1 | High while the controller drives the device data bus |
| mem_cs_n | output | 1 | Device chip select, active low |
| mem_oe_n | output | 1 | Device output enable, active low |
| mem_we_n | output | 1 | Device write enable, active low |

## Verification
Two functions can meet in one clock cycle: a register write and the acceptance of a bus request. The bench provokes this by raising `bus_cyc`/`bus_stb` on the same edge as a configuration write that disables the region. It expects that request to finish with an acknowledge and the old memory contents, and the next request to get an error. A scoreboard queue holds the expected response for every request. Monitors measure the length of each strobe, turnaround and write tail against the programmed counts.

// File: rtl/asram_pkg.sv
package asram_pkg;

    localparam int unsigned REG_OFF_W = 8;
    localparam int unsigned DATA_W    = 32;

    localparam logic [REG_OFF_W-1:0] OFF_CONFIG = 8'h18;
    localparam logic [REG_OFF_W-1:0] OFF_TIMING = 8'h1C;

    typedef logic [1:0] width_t;
    localparam width_t WIDTH_8   = 2'd0;
    localparam width_t WIDTH_16  = 2'd1;
    localparam width_t WIDTH_32  = 2'd2;
    localparam width_t WIDTH_BAD = 2'd3;

    localparam logic [2:0] MTYPE_ASRAM = 3'd2;

    typedef struct packed {
        logic [5:0] wgap;
        logic [3:0] whold;
        logic [3:0] wpulse;
        logic [3:0] turn;
        logic [7:0] rvalid;
    } timing_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ,
        ST_TURN,
        ST_WPULSE,
        ST_WHOLD,
        ST_WGAP,
        ST_ACK,
        ST_ERR
    } ctl_state_e;

endpackage

// File: rtl/asram_regs.sv
module asram_regs
    import asram_pkg::*;
#(
    parameter int unsigned OFF_W = REG_OFF_W,
    parameter int unsigned DW    = DATA_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_en,
    input  logic             reg_we,
    input  logic [OFF_W-1:0] reg_off,
    input  logic [DW-1:0]    reg_wdata,
    output logic [DW-1:0]    reg_rdata,
    output logic [DW-1:0]    cfg_q,
    output logic [DW-1:0]    tim_q
);

    logic wr_cfg;
    logic wr_tim;

    assign wr_cfg = reg_en && reg_we && (reg_off == OFF_CONFIG);
    assign wr_tim = reg_en && reg_we && (reg_off == OFF_TIMING);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
            tim_q <= '0;
        end else begin
            if (wr_cfg) cfg_q <= reg_wdata;
            if (wr_tim) tim_q <= reg_wdata;
        end
    end

    always_comb begin
        unique case (reg_off)
            OFF_CONFIG: reg_rdata = cfg_q;
            OFF_TIMING: reg_rdata = tim_q;
            default:    reg_rdata = '0;
        endcase
    end

    // R1: written word is held verbatim
    p_cfg_readback_r1: assert property (@(posedge clk) disable iff (!rst_n)
        wr_cfg |=> (cfg_q == $past(reg_wdata)));
    p_tim_readback_r1: assert property (@(posedge clk) disable iff (!rst_n)
        wr_tim |=> (tim_q == $past(reg_wdata)));

endmodule

// File: rtl/asram_decode.sv
module asram_decode
    import asram_pkg::*;
#(
    parameter int unsigned SEL_W = 8
) (
    input  logic [SEL_W-1:0] adr_sel,
    input  logic [SEL_W-1:0] cfg_sel,
    input  logic             cfg_enable,
    input  logic [2:0]       cfg_mtype,
    input  width_t           cfg_width,
    output logic             hit,
    output logic             bad_width
);

    assign hit       = cfg_enable && (cfg_mtype == MTYPE_ASRAM) && (adr_sel == cfg_sel);
    assign bad_width = (cfg_width == WIDTH_BAD);

endmodule

// File: rtl/asram_fsm.sv
module asram_fsm
    import asram_pkg::*;
#(
    parameter int unsigned AW = 21,
    parameter int unsigned DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req,
    input  logic          req_we,
    input  logic [AW-1:0] req_adr,
    input  logic [DW-1:0] req_dat,
    input  logic          hit,
    input  logic          bad_width,
    input  width_t        width,
    input  timing_t       tim,
    output logic          bus_ack,
    output logic          bus_err,
    output logic [DW-1:0] bus_dat_r,
    output logic [AW-1:0] mem_adr,
    output logic [DW-1:0] mem_dout,
    input  logic [DW-1:0] mem_din,
    output logic          mem_drive,
    output logic          mem_cs_n,
    output logic          mem_oe_n,
    output logic          mem_we_n
);

    localparam int unsigned CNT_W = 8;

    ctl_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic [1:0]       sub_q;
    logic [1:0]       sub_last;
    logic             we_q;
    logic [AW-1:0]    adr_q;
    logic [DW-1:0]    dat_q;
    width_t           wid_q;
    logic [DW-1:0]    rbuf_q;

    logic rd_done, turn_done, wp_done, wh_done, wg_done;

    assign rd_done   = (cnt_q == tim.rvalid);
    assign turn_done = (cnt_q == {4'b0, tim.turn});
    assign wp_done   = (cnt_q == {4'b0, tim.wpulse});
    assign wh_done   = (cnt_q == ({4'b0, tim.whold} - 8'd1));
    assign wg_done   = (cnt_q == ({2'b0, tim.wgap} - 8'd1));

    always_comb begin
        unique case (wid_q)
            WIDTH_8:  sub_last = 2'd3;
            WIDTH_16: sub_last = 2'd1;
            default:  sub_last = 2'd0;
        endcase
    end

    // next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (req) begin
                    if (hit && !bad_width) state_d = req_we ? ST_WPULSE : ST_READ;
                    else                   state_d = ST_ERR;
                end
            end
            ST_READ:   if (rd_done) state_d = ST_TURN;
            ST_TURN:   if (turn_done) state_d = (sub_q == sub_last) ? ST_ACK : ST_READ;
            ST_WPULSE: begin
                if (wp_done) begin
                    if (tim.whold != '0)     state_d = ST_WHOLD;
                    else if (tim.wgap != '0) state_d = ST_WGAP;
                    else                     state_d = ST_ACK;
                end
            end
            ST_WHOLD:  if (wh_done) state_d = (tim.wgap != '0) ? ST_WGAP : ST_ACK;
            ST_WGAP:   if (wg_done) state_d = ST_ACK;
            ST_ACK:    state_d = ST_IDLE;
            ST_ERR:    state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // state register, phase counter, access latch and read assembly
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            sub_q   <= '0;
            we_q    <= 1'b0;
            adr_q   <= '0;
            dat_q   <= '0;
            wid_q   <= WIDTH_32;
            rbuf_q  <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= (state_d != state_q) ? '0 : cnt_q + 8'd1;
            if (state_q == ST_IDLE && req) begin
                we_q   <= req_we;
                adr_q  <= req_adr;
                dat_q  <= req_dat;
                wid_q  <= width;
                sub_q  <= '0;
                rbuf_q <= '0;
            end
            if (state_q == ST_TURN && state_d == ST_READ) sub_q <= sub_q + 2'd1;
            if (state_q == ST_READ && rd_done) begin
                unique case (wid_q)
                    WIDTH_8:  rbuf_q[{sub_q, 3'b000} +: 8]     <= mem_din[7:0];
                    WIDTH_16: rbuf_q[{sub_q[0], 4'b0000} +: 16] <= mem_din[15:0];
                    default:  rbuf_q                            <= mem_din;
                endcase
            end
        end
    end

    // device address per access kind and width
    always_comb begin
        unique case (wid_q)
            WIDTH_8:  mem_adr = we_q ? adr_q : {adr_q[AW-1:2], sub_q};
            WIDTH_16: mem_adr = we_q ? {1'b0, adr_q[AW-1:1]} : {1'b0, adr_q[AW-1:2], sub_q[0]};
            default:  mem_adr = {2'b00, adr_q[AW-1:2]};
        endcase
    end

    assign mem_dout  = dat_q;
    assign bus_dat_r = rbuf_q;

    // strobes decoded from the state
    always_comb begin
        mem_cs_n  = 1'b1;
        mem_oe_n  = 1'b1;
        mem_we_n  = 1'b1;
        mem_drive = 1'b0;
        bus_ack   = 1'b0;
        bus_err   = 1'b0;
        unique case (state_q)
            ST_READ:   begin mem_cs_n = 1'b0; mem_oe_n = 1'b0; end
            ST_WPULSE: begin mem_cs_n = 1'b0; mem_we_n = 1'b0; mem_drive = 1'b1; end
            ST_WHOLD:  begin mem_cs_n = 1'b0; mem_drive = 1'b1; end
            ST_ACK:    bus_ack = 1'b1;
            ST_ERR:    bus_err = 1'b1;
            default:   ;
        endcase
    end

    // R12: strobes exclusive
    p_we_oe_excl_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !(!mem_we_n && !mem_oe_n));
    // R8: single-cycle acknowledge, never with error
    p_ack_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ack |=> !bus_ack);
    p_ack_err_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_ack && bus_err));
    // R2: error cycle leaves the device idle
    p_err_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |-> (mem_cs_n && mem_we_n && mem_oe_n));
    // R4: write strobe stays low until its count expires
    p_we_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_we_n && !wp_done && $stable(tim)) |=> !mem_we_n);

endmodule

// File: rtl/asram_cs_ctrl.sv
module asram_cs_ctrl
    import asram_pkg::*;
#(
    parameter int unsigned SEL_LSB = 21,
    parameter int unsigned SEL_W   = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_en,
    input  logic               reg_we,
    input  logic [7:0]         reg_off,
    input  logic [31:0]        reg_wdata,
    output logic [31:0]        reg_rdata,
    input  logic               bus_cyc,
    input  logic               bus_stb,
    input  logic               bus_we,
    input  logic [31:0]        bus_adr,
    input  logic [31:0]        bus_dat_w,
    output logic [31:0]        bus_dat_r,
    output logic               bus_ack,
    output logic               bus_err,
    output logic [SEL_LSB-1:0] mem_adr,
    output logic [31:0]        mem_dout,
    input  logic [31:0]        mem_din,
    output logic               mem_drive,
    output logic               mem_cs_n,
    output logic               mem_oe_n,
    output logic               mem_we_n
);

    localparam int unsigned SEL_MSB = SEL_LSB + SEL_W - 1;

    logic [31:0] cfg_q;
    logic [31:0] tim_q;
    logic        hit;
    logic        bad_width;
    timing_t     tim_f;
    width_t      cfg_width;
    logic        field_unused;

    assign tim_f     = tim_q[25:0];
    assign cfg_width = cfg_q[5:4];
    assign field_unused = ^{cfg_q[31:24], cfg_q[15:6], tim_q[31:26], bus_adr[31:SEL_MSB+1]};

    asram_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_en    (reg_en),
        .reg_we    (reg_we),
        .reg_off   (reg_off),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .cfg_q     (cfg_q),
        .tim_q     (tim_q)
    );

    asram_decode #(.SEL_W(SEL_W)) u_decode (
        .adr_sel    (bus_adr[SEL_MSB:SEL_LSB]),
        .cfg_sel    (cfg_q[23:16]),
        .cfg_enable (cfg_q[0]),
        .cfg_mtype  (cfg_q[3:1]),
        .cfg_width  (cfg_width),
        .hit        (hit),
        .bad_width  (bad_width)
    );

    asram_fsm #(.AW(SEL_LSB), .DW(32)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (bus_cyc && bus_stb),
        .req_we    (bus_we),
        .req_adr   (bus_adr[SEL_LSB-1:0]),
        .req_dat   (bus_dat_w),
        .hit       (hit),
        .bad_width (bad_width),
        .width     (cfg_width),
        .tim       (tim_f),
        .bus_ack   (bus_ack),
        .bus_err   (bus_err),
        .bus_dat_r (bus_dat_r),
        .mem_adr   (mem_adr),
        .mem_dout  (mem_dout),
        .mem_din   (mem_din),
        .mem_drive (mem_drive),
        .mem_cs_n  (mem_cs_n),
        .mem_oe_n  (mem_oe_n),
        .mem_we_n  (mem_we_n)
    );

endmodule

// File: tb/asram_cs_ctrl_test.sv
`timescale 1ns/1ps
module asram_cs_ctrl_test;

    localparam logic [31:0] BASE = 32'h0800_0000;  // select field 0x40

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_en = 0, reg_we = 0;
    logic [7:0]  reg_off = 0;
    logic [31:0] reg_wdata = 0, reg_rdata;
    logic        bus_cyc = 0, bus_stb = 0, bus_we = 0;
    logic [31:0] bus_adr = 0, bus_dat_w = 0, bus_dat_r;
    logic        bus_ack, bus_err;
    logic [20:0] mem_adr;
    logic [31:0] mem_dout, mem_din;
    logic        mem_drive, mem_cs_n, mem_oe_n, mem_we_n;

    always #4 clk = ~clk;

    asram_cs_ctrl uut (
        .clk(clk), .rst_n(rst_n),
        .reg_en(reg_en), .reg_we(reg_we), .reg_off(reg_off),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .bus_cyc(bus_cyc), .bus_stb(bus_stb), .bus_we(bus_we),
        .bus_adr(bus_adr), .bus_dat_w(bus_dat_w), .bus_dat_r(bus_dat_r),
        .bus_ack(bus_ack), .bus_err(bus_err),
        .mem_adr(mem_adr), .mem_dout(mem_dout), .mem_din(mem_din),
        .mem_drive(mem_drive), .mem_cs_n(mem_cs_n),
        .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n)
    );

    // device model: stores the whole driven word, returns it unmasked
    logic [31:0] mem [256];
    assign mem_din = mem[mem_adr[7:0]];
    always @(posedge clk) if (!mem_cs_n && !mem_we_n) mem[mem_adr[7:0]] <= mem_dout;

    int n_cmp = 0, n_bad = 0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic report();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    // scoreboard
    typedef struct {
        bit          is_err;
        bit          is_rd;
        logic [31:0] data;
        string       tag;
    } exp_t;
    exp_t sb[$];

    always @(negedge clk) begin
        if (rst_n && (bus_ack || bus_err)) begin
            chk(!(bus_ack && bus_err), "R8 ack with err", {30'b0, bus_ack, bus_err}, 32'h2);
            if (sb.size() == 0) begin
                chk(1'b0, "R8 unexpected response", {31'b0, bus_ack}, 32'h0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                chk(bus_err == e.is_err, {e.tag, " response kind"}, {31'b0, bus_err}, {31'b0, e.is_err});
                if (e.is_rd && !e.is_err)
                    chk(bus_dat_r == e.data, {e.tag, " read data"}, bus_dat_r, e.data);
            end
        end
    end

    // strobe timing monitors
    int exp_rdv = 0, exp_trz = 0, exp_wpw = 0, exp_tail = 1;
    int we_run = 0, oe_run = 0, gap = 0, tail_cnt = 0;
    bit gap_on = 0, tail_on = 0;
    logic prev_we = 1, prev_oe = 1;

    always @(negedge clk) begin
        if (rst_n) begin
            if (!mem_we_n || !mem_oe_n)
                chk(mem_we_n || mem_oe_n, "R12 we and oe both low", {30'b0, mem_we_n, mem_oe_n}, 32'h1);
            if (!mem_we_n) begin
                we_run++;
                chk(mem_drive && !mem_cs_n, "R4 drive/cs during pulse", {30'b0, mem_drive, mem_cs_n}, 32'h2);
            end else if (!prev_we) begin
                chk(we_run == exp_wpw + 1, "R4 write pulse length", we_run, exp_wpw + 1);
                we_run = 0; tail_on = 1; tail_cnt = 0;
            end
            if (tail_on) begin
                tail_cnt++;
                if (bus_ack) begin
                    chk(tail_cnt == exp_tail, "R9 write hold+gap to ack", tail_cnt, exp_tail);
                    tail_on = 0;
                end
            end
            if (!mem_oe_n) begin
                if (prev_oe && gap_on) begin
                    chk(gap == exp_trz + 1, "R6 turnaround length", gap, exp_trz + 1);
                    gap_on = 0;
                end
                oe_run++;
            end else if (!prev_oe) begin
                chk(oe_run == exp_rdv + 1, "R5 read strobe length", oe_run, exp_rdv + 1);
                oe_run = 0; gap_on = 1; gap = 1;
                chk(mem_cs_n, "R6 cs released in turnaround", {31'b0, mem_cs_n}, 32'h1);
            end else if (gap_on) begin
                gap++;
            end
            if (bus_ack || bus_err) gap_on = 0;
        end
        prev_we = mem_we_n;
        prev_oe = mem_oe_n;
    end

    // driver
    task automatic access(input bit we, input logic [31:0] adr, input logic [31:0] dat,
                          input int cyc_dly, input int stb_dly,
                          input bit exp_err, input logic [31:0] exp_dat, input string tag);
        exp_t e;
        e.is_err = exp_err; e.is_rd = !we; e.data = exp_dat; e.tag = tag;
        sb.push_back(e);
        repeat (cyc_dly) @(negedge clk);
        @(negedge clk);
        bus_cyc = 1; bus_we = we; bus_adr = adr; bus_dat_w = dat;
        repeat (stb_dly) @(negedge clk);
        bus_stb = 1;
        do @(negedge clk); while (!(bus_ack || bus_err));
        bus_cyc = 0; bus_stb = 0;
    endtask

    task automatic reg_wr(input logic [7:0] off, input logic [31:0] d);
        @(negedge clk);
        reg_en = 1; reg_we = 1; reg_off = off; reg_wdata = d;
        @(negedge clk);
        reg_en = 0; reg_we = 0;
    endtask

    task automatic reg_chk(input logic [7:0] off, input logic [31:0] exp, input string tag);
        @(negedge clk);
        reg_en = 1; reg_we = 0; reg_off = off;
        #1;
        chk(reg_rdata == exp, tag, reg_rdata, exp);
        reg_en = 0;
    endtask

    task automatic set_tim(input int wwd, input int wd, input int wpw, input int trz, input int rdv);
        logic [31:0] t;
        t = {6'h0, 6'(wwd), 4'(wd), 4'(wpw), 4'(trz), 8'(rdv)};
        reg_wr(8'h1C, t);
        exp_wwd_set(wwd, wd, wpw, trz, rdv);
    endtask

    task automatic exp_wwd_set(input int wwd, input int wd, input int wpw, input int trz, input int rdv);
        exp_rdv = rdv; exp_trz = trz; exp_wpw = wpw; exp_tail = wd + wwd + 1;
    endtask

    function automatic logic [31:0] cfg_word(input logic [1:0] bw);
        return 32'h0040_0005 | ({30'b0, bw} << 4);
    endfunction

    task automatic wait_idle();
        while (sb.size() != 0) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog expired actual=%h expected=%h", 32'h1, 32'h0);
        report();
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 32'h0;
        repeat (3) @(negedge clk);
        // reset state
        chk(!bus_ack && !bus_err, "R8 reset response idle", {30'b0, bus_ack, bus_err}, 32'h0);
        chk(mem_cs_n && mem_we_n && mem_oe_n, "R12 reset strobes high",
            {29'b0, mem_cs_n, mem_we_n, mem_oe_n}, 32'h7);
        rst_n = 1;
        reg_chk(8'h18, 32'h0, "R1 config reset value");
        reg_chk(8'h1C, 32'h0, "R1 timing reset value");

        // R1: exact readback including reserved bits
        reg_wr(8'h18, 32'hFF40_F025);
        reg_wr(8'h1C, 32'hFC12_3456);
        reg_chk(8'h18, 32'hFF40_F025, "R1 config readback");
        reg_chk(8'h1C, 32'hFC12_3456, "R1 timing readback");
        reg_chk(8'h20, 32'h0, "R1 unmapped offset");

        // 32-bit device, reserved config bits set
        set_tim(1, 1, 1, 0, 2);
        access(1, BASE, 32'hDEAD_BEEF, 0, 0, 0, 0, "R10 32b write");
        access(0, BASE, 0, 0, 0, 0, 32'hDEAD_BEEF, "R10 32b readback");
        for (int c = 0; c < 3; c++)
            for (int s = 0; s < 3; s++) begin
                logic [31:0] a, d;
                a = BASE + 32'h100 + 32'(4 * (c * 3 + s));
                d = {16'(c * 3 + s + 7), ~16'(c * 3 + s + 7)};
                access(1, a, d, c, s, 0, 0, "R10 delayed write");
                access(0, a, 0, c, s, 0, d, "R10 delayed readback");
            end
        wait_idle();
        set_tim(0, 0, 3, 2, 4);
        access(1, BASE + 32'h40, 32'h0BAD_F00D, 0, 1, 0, 0, "R4 long pulse write");
        access(0, BASE + 32'h40, 0, 1, 0, 0, 32'h0BAD_F00D, "R5 long strobe read");
        chk(mem[16] == 32'h0BAD_F00D, "R4 32b device address", mem[16], 32'h0BAD_F00D);

        // 16-bit device
        wait_idle();
        reg_wr(8'h18, cfg_word(2'd1));
        set_tim(0, 2, 0, 1, 1);
        access(1, BASE + 32'h10, 32'hFFFF_1234, 0, 0, 0, 0, "R4 16b write low");
        access(1, BASE + 32'h12, 32'h5555_ABCD, 0, 0, 0, 0, "R4 16b write high");
        access(0, BASE + 32'h10, 0, 0, 0, 0, 32'hABCD_1234, "R7 16b assembly");
        chk(mem[9][15:0] == 16'hABCD, "R4 16b device address", {16'b0, mem[9][15:0]}, 32'hABCD);

        // 8-bit device, several timings
        wait_idle();
        reg_wr(8'h18, cfg_word(2'd0));
        set_tim(2, 0, 2, 0, 0);
        access(1, BASE + 32'h20, 32'hAAAA_AA11, 0, 0, 0, 0, "R4 8b write 0");
        access(1, BASE + 32'h21, 32'h0000_0022, 1, 0, 0, 0, "R4 8b write 1");
        access(1, BASE + 32'h22, 32'hBBBB_BB33, 0, 2, 0, 0, "R4 8b write 2");
        access(1, BASE + 32'h23, 32'h0000_0044, 0, 0, 0, 0, "R4 8b write 3");
        access(0, BASE + 32'h20, 0, 0, 0, 0, 32'h4433_2211, "R7 8b assembly");
        wait_idle();
        set_tim(0, 0, 0, 3, 1);
        access(0, BASE + 32'h20, 0, 0, 0, 0, 32'h4433_2211, "R5 8b four sub-cycles");

        // R2 misses
        access(0, BASE + 32'h0020_0000, 0, 0, 0, 1, 0, "R2 select mismatch");
        wait_idle();
        reg_wr(8'h18, 32'h0040_0024);
        access(1, BASE, 32'h1, 0, 0, 1, 0, "R2 disabled region");
        wait_idle();
        reg_wr(8'h18, 32'h0040_0023);
        access(0, BASE, 0, 0, 0, 1, 0, "R2 wrong memory type");
        // R3 reserved width
        wait_idle();
        reg_wr(8'h18, cfg_word(2'd3));
        access(0, BASE, 0, 0, 0, 1, 0, "R3 reserved width");
        chk(mem[0] == 32'hDEAD_BEEF, "R2 miss left memory alone", mem[0], 32'hDEAD_BEEF);

        // R11: register write in the accepting cycle
        wait_idle();
        reg_wr(8'h18, cfg_word(2'd2));
        set_tim(0, 0, 0, 0, 1);
        begin
            exp_t e;
            e.is_err = 0; e.is_rd = 1; e.data = 32'hDEAD_BEEF; e.tag = "R11 old config used";
            sb.push_back(e);
        end
        @(negedge clk);
        bus_cyc = 1; bus_stb = 1; bus_we = 0; bus_adr = BASE;
        reg_en = 1; reg_we = 1; reg_off = 8'h18; reg_wdata = 32'h0040_0024;
        @(negedge clk);
        reg_en = 0; reg_we = 0;
        while (!(bus_ack || bus_err)) @(negedge clk);
        bus_cyc = 0; bus_stb = 0;
        access(0, BASE, 0, 0, 0, 1, 0, "R11 new config on next request");

        wait_idle();
        chk(sb.size() == 0, "R8 all responses seen", sb.size(), 0);
        report();
        $finish;
    end

endmodule